// File: doc/BRIEF.md
# Priority-Packed Peripheral Pin Crossbar

This block sits between a set of on-chip digital peripherals and the pads of the four lower I/O ports. Together these ports hold 32 pins by default. Three configuration bytes choose which peripherals reach the pads. The enabled peripheral signals are packed onto the pins in one fixed global priority order. Packing starts at pin 0 and moves upward, and no pin is ever skipped. A pin that no peripheral claims stays an ordinary GPIO pin, driven from the port data and direction inputs.

Each pin gets an output value, an output enable and a flag that marks it as peripheral-owned. Each peripheral input signal is fed from the pad that the signal was given. A signal with no pad reads an idle high level. The per-pin pad-mode bit (push-pull versus open-drain) passes straight through. The configuration is decoded into a registered pin map. The routing of data through that map is combinational.

The block has 24 peripheral signals. They are listed here in priority order with their signal index, and the pin order depends on this list:
- serial port 0: transmit 0, receive 1
- synchronous serial: clock 2, data-in 3, data-out 4, select 5
- two-wire bus: data 6, clock 7
- serial port 1: transmit 8, receive 9
- capture/compare channels 0 to 5: indices 10 to 15
- comparator 0 and 1 outputs: 16 and 17
- timer 0, 1 and 2 inputs: 18 to 20
- interrupt inputs 0 and 1: 21 and 22
- conversion start: 23, the lowest priority

Top module: `pin_crossbar`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, no pin is owned, no pin output enable is set and the overflow flag is 0.
- R2: The global enable is bit 0 of `cfg_c`. When it is 0, no pin is owned, every pin output enable is 0, every `periph_in` bit reads 1 and the overflow flag is 0.
- R3: The enable bits are as follows. `cfg_a` bit 0 enables signals 0 to 1, bit 1 enables 2 to 5, bit 2 enables 6 to 7 and bit 6 enables 8 to 9. `cfg_b` bit k enables signal 16+k. Signal s is placed on pin p, where p is the number of enabled signals with a lower index. The owned pins are therefore always pins 0 to n-1.
- R4: On an unowned pin p, `pin_out[p]` equals `port_dout[p]`. `pin_oe[p]` equals `port_dir[p]` while the global enable is set.
- R5: On a pin owned by signal s, `pin_out` equals `periph_out[s]` and `pin_oe` equals `periph_oe[s]`.
- R6: `periph_in[s]` equals the `pin_in` bit of the pin given to signal s. If signal s has no pin, `periph_in[s]` reads 1.
- R7: The field `cfg_a[5:3]` = n enables the first n capture channels. Values above 6 act as 6.
- R8: Enabled signals that fall beyond the last pin get no pin, and `overflow` is set. `overflow` is only ever 1 when every pin is owned.
- R9: A change of the configuration bytes changes the pin map at the next rising clock edge, not before it.
- R10: `pin_pp` always equals `port_pp`.
- R11: `cfg_a` bit 7 and `cfg_c` bits 7 to 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_a | input | 8 | Enables for the serial and bus peripherals, plus the capture channel count |
| cfg_b | input | 8 | Enables for the single-pin signals 16 to 23 |
| cfg_c | input | 8 | Bit 0 is the global crossbar enable |
| port_dout | input | N_PIN | GPIO output data |
| port_dir | input | N_PIN | GPIO direction, 1 = drive |
| port_pp | input | N_PIN | Pad mode, 1 = push-pull |
| periph_out | input | 24 | Peripheral output values, by signal index |
| periph_oe | input | 24 | Peripheral output enables, by signal index |
| pin_in | input | N_PIN | Pad input levels |
| pin_out | output | N_PIN | Pad output values |
| pin_oe | output | N_PIN | Pad output enables |
| pin_pp | output | N_PIN | Pad mode bits, passed through |
| pin_owned | output | N_PIN | 1 where a peripheral owns the pin |
| periph_in | output | 24 | Pad levels routed to each peripheral signal |
| overflow | output | 1 | Enabled signals exceed the pin count |

## Verification
Two things can happen in the same cycle: the pin map is rebuilt after a configuration write, and the data and pad traffic keeps flowing through the old or the new map. The bench writes a new configuration on a falling edge and drives fresh data at once. It then checks that the outputs still follow the old map before the rising edge and the new map after it. A second instance with 16 pins runs through the same vectors. On that instance, packing and overflow happen in the same decode, and the bench checks which signals keep a pad and that every cut-off signal reads idle high.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int N_SIG    = 24;
  localparam int CAP_MAX  = 6;
  localparam int CAP_BASE = 10;
  localparam int ONE_BASE = 16;
  localparam int GLB_BIT  = 0;
  localparam int SIG_W    = $clog2(N_SIG);
  localparam int CNT_W    = $clog2(N_SIG + 1);

  typedef enum logic [SIG_W-1:0] {
    SIG_U0_TX = 5'd0, SIG_U0_RX = 5'd1,
    SIG_SS_CK = 5'd2, SIG_SS_DI = 5'd3, SIG_SS_DO = 5'd4, SIG_SS_SEL = 5'd5,
    SIG_TW_DA = 5'd6, SIG_TW_CK = 5'd7,
    SIG_U1_TX = 5'd8, SIG_U1_RX = 5'd9,
    SIG_CAP0  = 5'd10,
    SIG_CMP0  = 5'd16, SIG_CMP1 = 5'd17,
    SIG_TM0   = 5'd18, SIG_TM1 = 5'd19, SIG_TM2 = 5'd20,
    SIG_IRQ0  = 5'd21, SIG_IRQ1 = 5'd22,
    SIG_CONV  = 5'd23
  } sig_id_e;

  // number of capture channels asked for by the 3-bit field, clamped
  function automatic int cap_count(input logic [2:0] fld);
    return (int'(fld) > CAP_MAX) ? CAP_MAX : int'(fld);
  endfunction

  // per-signal enable vector in priority order
  function automatic logic [N_SIG-1:0] signal_enables(input logic [7:0] a,
                                                      input logic [7:0] b,
                                                      input logic [7:0] c);
    logic [N_SIG-1:0] e;
    int n;
    e = '0;
    n = cap_count(a[5:3]);
    if (c[GLB_BIT]) begin
      e[SIG_U0_RX:SIG_U0_TX]  = {2{a[0]}};
      e[SIG_SS_SEL:SIG_SS_CK] = {4{a[1]}};
      e[SIG_TW_CK:SIG_TW_DA]  = {2{a[2]}};
      e[SIG_U1_RX:SIG_U1_TX]  = {2{a[6]}};
      for (int i = 0; i < CAP_MAX; i++) e[CAP_BASE+i] = (i < n);
      e[N_SIG-1:ONE_BASE] = b;
    end
    return e;
  endfunction

  // pin position of signal s: enabled signals of higher priority
  function automatic logic [CNT_W-1:0] prefix_pos(input logic [N_SIG-1:0] en,
                                                  input int s);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < N_SIG; i++)
      if (i < s && en[i]) n = n + CNT_W'(1);
    return n;
  endfunction
endpackage

// File: rtl/pxb_alloc.sv
module pxb_alloc import pxb_pkg::*; #(
  parameter int N_PIN = 32,
  localparam int PIN_W = (N_PIN > 1) ? $clog2(N_PIN) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [7:0]                     cfg_a,
  input  logic [7:0]                     cfg_b,
  input  logic [7:0]                     cfg_c,
  output logic                           on_q,
  output logic [N_PIN-1:0]               own_v,
  output logic [N_PIN-1:0][SIG_W-1:0]    own_idx,
  output logic [N_SIG-1:0]               sig_v,
  output logic [N_SIG-1:0][PIN_W-1:0]    sig_pos,
  output logic                           ovf_q
);
  logic [N_SIG-1:0]            en_c;
  logic [N_SIG-1:0]            sig_v_d;
  logic [N_SIG-1:0][PIN_W-1:0] sig_pos_d;
  logic [N_PIN-1:0]            own_v_d;
  logic [N_PIN-1:0][SIG_W-1:0] own_idx_d;
  logic                        ovf_d;

  always_comb begin
    en_c = signal_enables(cfg_a, cfg_b, cfg_c);
    for (int s = 0; s < N_SIG; s++) begin
      logic [CNT_W-1:0] pos;
      pos          = prefix_pos(en_c, s);
      sig_v_d[s]   = en_c[s] && (int'(pos) < N_PIN);
      sig_pos_d[s] = PIN_W'(pos);
    end
    for (int p = 0; p < N_PIN; p++) begin
      own_v_d[p]   = 1'b0;
      own_idx_d[p] = '0;
      for (int s = 0; s < N_SIG; s++)
        if (sig_v_d[s] && sig_pos_d[s] == PIN_W'(p)) begin
          own_v_d[p]   = 1'b1;
          own_idx_d[p] = SIG_W'(s);
        end
    end
    ovf_d = $countones(en_c) > N_PIN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      own_v   <= '0;
      own_idx <= '0;
      sig_v   <= '0;
      sig_pos <= '0;
      ovf_q   <= 1'b0;
    end else begin
      on_q    <= cfg_c[GLB_BIT];
      own_v   <= own_v_d;
      own_idx <= own_idx_d;
      sig_v   <= sig_v_d;
      sig_pos <= sig_pos_d;
      ovf_q   <= ovf_d;
    end
  end
endmodule

// File: rtl/pxb_pin_mux.sv
module pxb_pin_mux import pxb_pkg::*; #(
  parameter int N_PIN = 32
) (
  input  logic                        on_q,
  input  logic [N_PIN-1:0]            own_v,
  input  logic [N_PIN-1:0][SIG_W-1:0] own_idx,
  input  logic [N_SIG-1:0]            periph_out,
  input  logic [N_SIG-1:0]            periph_oe,
  input  logic [N_PIN-1:0]            port_dout,
  input  logic [N_PIN-1:0]            port_dir,
  output logic [N_PIN-1:0]            pin_out,
  output logic [N_PIN-1:0]            pin_oe
);
  for (genvar p = 0; p < N_PIN; p++) begin : g_pin
    assign pin_out[p] = own_v[p] ? periph_out[own_idx[p]] : port_dout[p];
    assign pin_oe[p]  = own_v[p] ? periph_oe[own_idx[p]]  : (port_dir[p] & on_q);
  end
endmodule

// File: rtl/pxb_in_route.sv
module pxb_in_route import pxb_pkg::*; #(
  parameter int N_PIN = 32,
  localparam int PIN_W = (N_PIN > 1) ? $clog2(N_PIN) : 1
) (
  input  logic [N_SIG-1:0]            sig_v,
  input  logic [N_SIG-1:0][PIN_W-1:0] sig_pos,
  input  logic [N_PIN-1:0]            pin_in,
  output logic [N_SIG-1:0]            periph_in
);
  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    assign periph_in[s] = sig_v[s] ? pin_in[sig_pos[s]] : 1'b1;
  end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar import pxb_pkg::*; #(
  parameter int N_PIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       cfg_a,
  input  logic [7:0]       cfg_b,
  input  logic [7:0]       cfg_c,
  input  logic [N_PIN-1:0] port_dout,
  input  logic [N_PIN-1:0] port_dir,
  input  logic [N_PIN-1:0] port_pp,
  input  logic [N_SIG-1:0] periph_out,
  input  logic [N_SIG-1:0] periph_oe,
  input  logic [N_PIN-1:0] pin_in,
  output logic [N_PIN-1:0] pin_out,
  output logic [N_PIN-1:0] pin_oe,
  output logic [N_PIN-1:0] pin_pp,
  output logic [N_PIN-1:0] pin_owned,
  output logic [N_SIG-1:0] periph_in,
  output logic             overflow
);
  localparam int PIN_W = (N_PIN > 1) ? $clog2(N_PIN) : 1;

  logic                        xbar_on;
  logic [N_PIN-1:0]            own_v;
  logic [N_PIN-1:0][SIG_W-1:0] own_idx;
  logic [N_SIG-1:0]            sig_valid;
  logic [N_SIG-1:0][PIN_W-1:0] sig_pos;
  logic                        unused_cfg;

  assign unused_cfg = ^{cfg_a[7], cfg_c[7:1]};

  pxb_alloc #(.N_PIN(N_PIN)) alloc_i (
    .clk(clk), .rst_n(rst_n), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .on_q(xbar_on), .own_v(own_v), .own_idx(own_idx),
    .sig_v(sig_valid), .sig_pos(sig_pos), .ovf_q(overflow)
  );

  pxb_pin_mux #(.N_PIN(N_PIN)) mux_i (
    .on_q(xbar_on), .own_v(own_v), .own_idx(own_idx),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .port_dout(port_dout), .port_dir(port_dir),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  pxb_in_route #(.N_PIN(N_PIN)) route_i (
    .sig_v(sig_valid), .sig_pos(sig_pos), .pin_in(pin_in), .periph_in(periph_in)
  );

  assign pin_owned = own_v;
  assign pin_pp    = port_pp;
endmodule

// File: rtl/pin_crossbar_chk.sv
module pin_crossbar_chk #(
  parameter int N_PIN = 32,
  parameter int N_SIG = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_c,
  input logic [N_PIN-1:0] pin_owned,
  input logic [N_PIN-1:0] pin_oe,
  input logic [N_SIG-1:0] sig_valid,
  input logic             overflow
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_owned == '0 && pin_oe == '0 && !overflow));

  // R2
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_c[0]) |-> (pin_owned == '0 && pin_oe == '0 && !overflow));

  // R3
  packed_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_owned & (pin_owned + 1'b1)) == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (&pin_owned));

  // R6
  route_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sig_valid) == $countones(pin_owned));
endmodule

bind pin_crossbar pin_crossbar_chk #(.N_PIN(N_PIN), .N_SIG(pxb_pkg::N_SIG)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_c(cfg_c), .pin_owned(pin_owned),
  .pin_oe(pin_oe), .sig_valid(sig_valid), .overflow(overflow)
);

// File: tb/pin_crossbar_tb_top.sv
`timescale 1ns/1ps
module pin_crossbar_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_a = '0, cfg_b = '0, cfg_c = '0;
  logic [31:0] port_dout = '0, port_dir = '0, port_pp = '0, pin_in = '0;
  logic [23:0] periph_out = '0, periph_oe = '0;
  logic [31:0] pin_out, pin_oe, pin_pp, pin_owned;
  logic [23:0] periph_in;
  logic        overflow;
  logic [15:0] s_out, s_oe, s_pp, s_owned;
  logic [23:0] s_in;
  logic        s_ovf;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pin_crossbar #(.N_PIN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .port_dout(port_dout), .port_dir(port_dir), .port_pp(port_pp),
    .periph_out(periph_out), .periph_oe(periph_oe), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pp(pin_pp), .pin_owned(pin_owned),
    .periph_in(periph_in), .overflow(overflow)
  );

  pin_crossbar #(.N_PIN(16)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_c(cfg_c),
    .port_dout(port_dout[15:0]), .port_dir(port_dir[15:0]), .port_pp(port_pp[15:0]),
    .periph_out(periph_out), .periph_oe(periph_oe), .pin_in(pin_in[15:0]),
    .pin_out(s_out), .pin_oe(s_oe), .pin_pp(s_pp), .pin_owned(s_owned),
    .periph_in(s_in), .overflow(s_ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void give(inout int own[32], inout int nxt, inout bit ovf,
                               input int np, input int sig);
    if (nxt < np) own[nxt] = sig;
    else ovf = 1'b1;
    nxt++;
  endfunction

  // independent allocator: walk groups, hand out the next free pin
  function automatic void model(input logic [7:0] a, input logic [7:0] b,
                                input logic [7:0] c, input int np,
                                output int own[32], output bit ovf);
    int nxt, base, capn;
    int sizes[4];
    bit on[4];
    sizes = '{2, 4, 2, 2};
    on = '{a[0], a[1], a[2], a[6]};
    for (int p = 0; p < 32; p++) own[p] = -1;
    ovf = 1'b0; nxt = 0; base = 0;
    if (!c[0]) return;
    for (int g = 0; g < 4; g++) begin
      if (on[g]) for (int k = 0; k < sizes[g]; k++) give(own, nxt, ovf, np, base + k);
      base += sizes[g];
    end
    capn = (a[5:3] > 3'd6) ? 6 : int'(a[5:3]);
    for (int k = 0; k < capn; k++) give(own, nxt, ovf, np, base + k);
    base += 6;
    for (int k = 0; k < 8; k++) if (b[k]) give(own, nxt, ovf, np, base + k);
  endfunction

  task automatic compare_all(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    int own[32];
    int owns[32];
    bit ovf, ovfs;
    logic [31:0] e_out, e_oe, e_own;
    logic [23:0] e_in, e_ins;
    model(a, b, c, 32, own, ovf);
    model(a, b, c, 16, owns, ovfs);
    e_in = '1; e_ins = '1;
    for (int p = 0; p < 32; p++) begin
      e_own[p] = own[p] >= 0;
      e_out[p] = (own[p] >= 0) ? periph_out[own[p]] : port_dout[p];
      e_oe[p]  = (own[p] >= 0) ? periph_oe[own[p]] : (c[0] & port_dir[p]);
      if (own[p] >= 0) e_in[own[p]] = pin_in[p];
      if (p < 16 && owns[p] >= 0) e_ins[owns[p]] = pin_in[p];
    end
    chk(pin_owned == e_own, "R3 owned map", 64'(pin_owned), 64'(e_own));
    chk(pin_out == e_out, "R4/R5 pin_out", 64'(pin_out), 64'(e_out));
    chk(pin_oe == e_oe, "R4/R5 pin_oe", 64'(pin_oe), 64'(e_oe));
    chk(periph_in == e_in, "R6 periph_in", 64'(periph_in), 64'(e_in));
    chk(overflow == ovf, "R8 overflow 32", 64'(overflow), 64'(ovf));
    chk(s_in == e_ins, "R6 periph_in 16-pin", 64'(s_in), 64'(e_ins));
    chk(s_ovf == ovfs, "R8 overflow 16-pin", 64'(s_ovf), 64'(ovfs));
  endtask

  task automatic scramble();
    port_dout = $urandom; port_dir = $urandom; port_pp = $urandom; pin_in = $urandom;
    periph_out = 24'($urandom); periph_oe = 24'($urandom);
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    @(negedge clk);
    cfg_a = a; cfg_b = b; cfg_c = c;
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < 2; r++) begin
      scramble();
      #1;
      compare_all(a, b, c);
    end
  endtask

  // {ovf16, cfg_a, cfg_b, cfg_c, pins used of 32}
  localparam logic [32:0] VEC [11] = '{
    {1'b0, 8'h00, 8'h00, 8'h01, 8'd0},   // nothing enabled
    {1'b0, 8'h01, 8'h00, 8'h01, 8'd2},   // R3 serial 0
    {1'b0, 8'h02, 8'h00, 8'h01, 8'd4},   // R3 sync serial
    {1'b0, 8'h47, 8'h00, 8'h01, 8'd10},  // R3 four groups
    {1'b0, 8'h38, 8'h00, 8'h01, 8'd6},   // R7 field 7 clamps to 6
    {1'b1, 8'h7F, 8'hFF, 8'h01, 8'd24},  // R8 everything
    {1'b0, 8'h80, 8'h80, 8'hFF, 8'd1},   // R11 reserved bits set
    {1'b0, 8'hFF, 8'hFF, 8'h00, 8'd0},   // R2 global off
    {1'b0, 8'h2B, 8'h41, 8'h01, 8'd13},  // R7 field 5
    {1'b1, 8'h7E, 8'h0F, 8'h01, 8'd18},  // R8 small instance cut
    {1'b0, 8'h1C, 8'h00, 8'h01, 8'd5}    // R7 field 3
  };

  initial begin
    logic [7:0] ra, rb;
    // R1 reset state with everything requested
    cfg_a = 8'hFF; cfg_b = 8'hFF; cfg_c = 8'h01; port_dir = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pin_owned == '0, "R1 owned in reset", 64'(pin_owned), 64'd0);
    chk(pin_oe == '0, "R1 oe in reset", 64'(pin_oe), 64'd0);
    chk(!overflow && !s_ovf, "R1 overflow in reset", 64'({overflow, s_ovf}), 64'd0);
    cfg_a = '0; cfg_b = '0;
    rst_n = 1'b1;

    for (int v = 0; v < 11; v++) begin
      apply(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8]);
      chk($countones(pin_owned) == int'(VEC[v][7:0]), "R3 pins used",
          64'($countones(pin_owned)), 64'(VEC[v][7:0]));
      chk(s_ovf == VEC[v][32], "R8 16-pin overflow vector", 64'(s_ovf), 64'(VEC[v][32]));
    end

    // R2 global off: peripheral inputs idle, no drive
    apply(8'hFF, 8'hFF, 8'hFE);
    chk(periph_in == '1 && pin_oe == '0, "R2 off idle", 64'({periph_in, pin_oe}),
        64'({24'hFFFFFF, 32'h0}));

    // R9 map changes only at the next rising edge
    apply(8'h00, 8'h00, 8'h01);
    @(negedge clk);
    cfg_a = 8'h01; cfg_b = 8'h01;
    #1;
    chk(pin_owned == '0, "R9 before edge", 64'(pin_owned), 64'd0);
    @(negedge clk);
    chk(pin_owned == 32'h7, "R9 after edge", 64'(pin_owned), 64'h7);

    // R11 reserved bits of cfg_c / cfg_a change nothing
    apply(8'h03, 8'h10, 8'h01);
    begin
      logic [31:0] o1;
      o1 = pin_owned;
      apply(8'h83, 8'h10, 8'hFF);
      chk(pin_owned == o1, "R11 reserved ignored", 64'(pin_owned), 64'(o1));
    end

    // R10 mode pass-through
    scramble();
    #1;
    chk(pin_pp == port_pp && s_pp == port_pp[15:0], "R10 pad mode",
        64'(pin_pp), 64'(port_pp));

    // random enable patterns against the model
    for (int i = 0; i < 40; i++) begin
      ra = 8'($urandom); rb = 8'($urandom);
      apply(ra, rb, 8'($urandom) | 8'h01);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule